// File: doc/BRIEF.md
# Set/Clear Interrupt Controller

This block gathers up to 32 interrupt inputs and presents them to a processor as two request lines and one wake line. Software configures it over a simple 32-bit register bus. Each control word is a plane of per-source bits. Every plane has two addresses. Writing ones at the first address sets the selected bits. Writing ones at the second address, four bytes higher, clears them. No read-modify-write is ever needed, so several agents can change different sources without racing each other.

Each source has a three-bit trigger code, built from one bit in each of three configuration planes. The code selects rising edge, falling edge, both edges, active-high level, active-low level, or off. Raw inputs pass through a two-flop synchroniser. Edge events are caught in sticky rising and falling capture words, which software clears by writing ones. A source contributes to a request line only while its mask bit is set. Its steering bit picks one of the two request lines. For each request line, a readable word shows the sources currently contributing to it.

Top module: `sc_intc_top`

## Requirements
- R1: After reset, all three trigger planes, mask, steering and wake planes, both capture words and the test word read 0. The source plane reads 0xFFFFFFFF. req0, req1 and wake are low.
- R2: Each plane has a set address and a clear address. Writing ones at the set address sets exactly those bits. Writing ones at the clear address clears exactly those bits, and leaves the other bits unchanged. The address pairs are: trig0 0x40/0x44, trig1 0x48/0x4C, trig2 0x50/0x54, source 0x58/0x5C, steer 0x60/0x64, wake 0x68/0x6C, mask 0x70/0x74. Reading a set address returns the plane.
- R3: The trigger code of source n is {trig2[n],trig1[n],trig0[n]}. The codes mean: 001 rising edge, 010 falling edge, 011 both edges, 101 input high, 110 input low. Every other code, including 000, disables the source, and a disabled source captures no edges.
- R4: The rising capture word is read at 0x78 and the falling capture word at 0x7C. A captured bit stays set after the input returns to idle. Writing ones to either address clears those bits. An edge arriving in the same cycle as the clear write keeps its bit set.
- R5: A read at 0x54 returns the pending word of req0. A read at 0x5C returns the pending word of req1. Writes at these addresses still clear trig2 and source bits.
- R6: A source with steer bit 1 goes to req0. A source with steer bit 0 goes to req1. Each request line is high whenever its pending word is nonzero.
- R7: A source with a clear mask bit contributes to neither pending word. Setting the mask bit lets the source contribute again.
- R8: wake is high exactly when some source with its wake bit set has an active condition.
- R9: An input change reaches a level condition on the second rising clock edge after it is applied. It sets a capture bit on the third rising clock edge.
- R10: The test word at 0x80 holds the last value written to it. Reads of unmapped addresses such as 0x44 return 0.
- R11: A read issued with rd_en returns rdata with rvalid high one cycle later. There is exactly one rvalid for each read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, one cycle after rd_en |
| rvalid | output | 1 | Read data valid |
| src_in | input | 32 | Raw interrupt inputs |
| req0 | output | 1 | Request line 0, higher priority |
| req1 | output | 1 | Request line 1 |
| wake | output | 1 | Wake indication |

## Verification
The sources are configured with one trigger code each: rising, falling, both, high, low and off. Their inputs are then driven through low-to-high and high-to-low swings. This separates edge capture from live level, and it shows that a disabled source and a source of the wrong polarity ignore the swing. Request lines are sampled cycle by cycle after a single input change, which pins the synchroniser latency separately for level and edge modes. A capture-clear write is issued in the exact cycle of a new edge, to show that the edge wins. Mask, steering and wake bits are then flipped one at a time. Each change must move the pending words, request lines and wake output in the expected way, and must leave the other line alone.

// File: rtl/sc_intc_pkg.sv
package sc_intc_pkg;
  localparam int NSRC   = 32;
  localparam int AW     = 8;
  localparam int NPLANE = 7;
  localparam logic [AW-1:0] PLANE_BASE = 8'h40;
  localparam logic [AW-1:0] ADDR_RISE  = 8'h78;
  localparam logic [AW-1:0] ADDR_FALL  = 8'h7C;
  localparam logic [AW-1:0] ADDR_PND0  = 8'h54;
  localparam logic [AW-1:0] ADDR_PND1  = 8'h5C;
  localparam logic [AW-1:0] ADDR_TEST  = 8'h80;
  // plane order matters: it fixes each plane's address
  localparam int PL_TRIG0 = 0;
  localparam int PL_TRIG1 = 1;
  localparam int PL_TRIG2 = 2;
  localparam int PL_SRC   = 3;
  localparam int PL_STEER = 4;
  localparam int PL_WAKE  = 5;
  localparam int PL_MASK  = 6;

  typedef enum logic [2:0] {
    TRG_OFF  = 3'b000,
    TRG_RISE = 3'b001,
    TRG_FALL = 3'b010,
    TRG_BOTH = 3'b011,
    TRG_HIGH = 3'b101,
    TRG_LOW  = 3'b110
  } trig_e;

  function automatic logic [AW-1:0] set_addr(input int p);
    set_addr = PLANE_BASE + AW'(8 * p);
  endfunction

  function automatic logic [AW-1:0] clr_addr(input int p);
    clr_addr = PLANE_BASE + AW'(8 * p + 4);
  endfunction

  function automatic logic catches_rise(input logic [2:0] c);
    catches_rise = (c == TRG_RISE) || (c == TRG_BOTH);
  endfunction

  function automatic logic catches_fall(input logic [2:0] c);
    catches_fall = (c == TRG_FALL) || (c == TRG_BOTH);
  endfunction

  function automatic logic is_edge(input logic [2:0] c);
    is_edge = catches_rise(c) || catches_fall(c);
  endfunction

  // active condition of one source from its code, level and captures
  function automatic logic src_active(input logic [2:0] c, input logic lvl,
                                      input logic rcap, input logic fcap);
    case (c)
      TRG_RISE, TRG_FALL, TRG_BOTH: src_active = rcap | fcap;
      TRG_HIGH: src_active = lvl;
      TRG_LOW:  src_active = ~lvl;
      default:  src_active = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/sc_intc_plane.sv
module sc_intc_plane #(
  parameter int W = 32,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [W-1:0] wd,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)      q <= RST_VAL;
    else if (set_we) q <= q | wd;
    else if (clr_we) q <= q & ~wd;
  end

  a_r2_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
    set_we |=> ((q & $past(wd)) == $past(wd)));
  a_r2_clr_bits: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((q & $past(wd)) == '0));
  a_r2_others_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (set_we || clr_we) |=> ((q & ~$past(wd)) == ($past(q) & ~$past(wd))));
endmodule

// File: rtl/sc_intc_sync.sv
module sc_intc_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise_evt,
  output logic [W-1:0] fall_evt
);
  logic [W-1:0] stage1, prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1 <= '0;
      lvl    <= '0;
      prev   <= '0;
    end else begin
      stage1 <= raw;
      lvl    <= stage1;
      prev   <= lvl;
    end
  end

  assign rise_evt = lvl & ~prev;
  assign fall_evt = ~lvl & prev;

  a_r9_two_stage: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ##1 (lvl == $past(raw, 2)));
endmodule

// File: rtl/sc_intc_eval.sv
module sc_intc_eval
  import sc_intc_pkg::*;
#(
  parameter int W = NSRC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] trig0,
  input  logic [W-1:0] trig1,
  input  logic [W-1:0] trig2,
  input  logic [W-1:0] steer,
  input  logic [W-1:0] wake_en,
  input  logic [W-1:0] mask,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] rise_evt,
  input  logic [W-1:0] fall_evt,
  input  logic [W-1:0] rise_clr,
  input  logic [W-1:0] fall_clr,
  output logic [W-1:0] rise_cap,
  output logic [W-1:0] fall_cap,
  output logic [W-1:0] pend0,
  output logic [W-1:0] pend1,
  output logic         wake
);
  logic [W-1:0] rise_mode, fall_mode, active, rise_hit, fall_hit;

  for (genvar n = 0; n < W; n++) begin : g_src
    logic [2:0] code;
    assign code         = {trig2[n], trig1[n], trig0[n]};
    assign rise_mode[n] = catches_rise(code);
    assign fall_mode[n] = catches_fall(code);
    assign active[n]    = src_active(code, lvl[n], rise_cap[n], fall_cap[n]);
  end

  assign rise_hit = rise_evt & rise_mode;
  assign fall_hit = fall_evt & fall_mode;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rise_cap <= '0;
      fall_cap <= '0;
    end else begin
      rise_cap <= (rise_cap & ~rise_clr) | rise_hit;
      fall_cap <= (fall_cap & ~fall_clr) | fall_hit;
    end
  end

  assign pend0 = active & mask & steer;
  assign pend1 = active & mask & ~steer;
  assign wake  = |(active & wake_en);

  a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(rise_cap) & ~$past(rise_clr)) & ~rise_cap) == '0));
  a_r4_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((rise_cap & $past(rise_hit)) == $past(rise_hit)));
  a_r3_mode_gated: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((fall_cap & ~$past(fall_cap)) & ~$past(fall_mode)) == '0));
  a_r7_mask_gates: assert property (@(posedge clk) disable iff (!rst_n)
    (((pend0 | pend1) & ~mask) == '0));
endmodule

// File: rtl/sc_intc_top.sv
module sc_intc_top
  import sc_intc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [7:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        rvalid,
  input  logic [31:0] src_in,
  output logic        req0,
  output logic        req1,
  output logic        wake
);
  logic [NSRC-1:0] plane_q [NPLANE];
  logic [NSRC-1:0] lvl, rise_evt, fall_evt, rise_cap, fall_cap, pend0, pend1;
  logic [NSRC-1:0] rise_clr, fall_clr, test_q, rd_mux;

  for (genvar p = 0; p < NPLANE; p++) begin : g_plane
    localparam logic [NSRC-1:0] RV = (p == PL_SRC) ? '1 : '0;
    logic set_hit, clr_hit;
    assign set_hit = wr_en && (addr == set_addr(p));
    assign clr_hit = wr_en && (addr == clr_addr(p));
    sc_intc_plane #(.W(NSRC), .RST_VAL(RV)) u_plane (
      .clk(clk), .rst_n(rst_n), .set_we(set_hit), .clr_we(clr_hit),
      .wd(wdata), .q(plane_q[p]));
  end

  assign rise_clr = (wr_en && addr == ADDR_RISE) ? wdata : '0;
  assign fall_clr = (wr_en && addr == ADDR_FALL) ? wdata : '0;

  sc_intc_sync #(.W(NSRC)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw(src_in), .lvl(lvl),
    .rise_evt(rise_evt), .fall_evt(fall_evt));

  sc_intc_eval #(.W(NSRC)) u_eval (
    .clk(clk), .rst_n(rst_n),
    .trig0(plane_q[PL_TRIG0]), .trig1(plane_q[PL_TRIG1]),
    .trig2(plane_q[PL_TRIG2]), .steer(plane_q[PL_STEER]),
    .wake_en(plane_q[PL_WAKE]), .mask(plane_q[PL_MASK]),
    .lvl(lvl), .rise_evt(rise_evt), .fall_evt(fall_evt),
    .rise_clr(rise_clr), .fall_clr(fall_clr),
    .rise_cap(rise_cap), .fall_cap(fall_cap),
    .pend0(pend0), .pend1(pend1), .wake(wake));

  always_ff @(posedge clk) begin
    if (!rst_n) test_q <= '0;
    else if (wr_en && addr == ADDR_TEST) test_q <= wdata;
  end

  always_comb begin
    rd_mux = '0;
    for (int p = 0; p < NPLANE; p++)
      if (addr == set_addr(p)) rd_mux = plane_q[p];
    if (addr == ADDR_PND0) rd_mux = pend0;
    if (addr == ADDR_PND1) rd_mux = pend1;
    if (addr == ADDR_RISE) rd_mux = rise_cap;
    if (addr == ADDR_FALL) rd_mux = fall_cap;
    if (addr == ADDR_TEST) rd_mux = test_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_en;
      if (rd_en) rdata <= rd_mux;
    end
  end

  assign req0 = |pend0;
  assign req1 = |pend1;

  a_r11_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rvalid);
  a_r11_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rvalid);
  a_r7_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (plane_q[PL_MASK] == '0) |-> (!req0 && !req1));
  a_r6_steer0_only: assert property (@(posedge clk) disable iff (!rst_n)
    (plane_q[PL_STEER] == '0) |-> !req0);
endmodule

// File: tb/test_sc_intc_top.sv
module test_sc_intc_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, src_in = '0;
  logic [31:0] rdata;
  logic        rvalid, req0, req1, wake;

  always #2.5 clk = ~clk;

  sc_intc_top i_sc_intc_top (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .src_in(src_in),
    .req0(req0), .req1(req1), .wake(wake));

  typedef struct {
    logic [31:0] exp;
    string       req;
  } item_t;
  item_t sb[$];

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: issue a read and push its expected value
  task automatic rd_exp(input logic [7:0] a, input logic [31:0] e, input string req);
    item_t it;
    it.exp = e; it.req = req;
    sb.push_back(it);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // monitor: compare each returned word with the queue head
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      if (sb.size() == 0) check("R11 extra rvalid", 32'h1, 32'h0);
      else begin
        item_t it;
        it = sb.pop_front();
        check(it.req, rdata, it.exp);
      end
    end
  end

  initial begin
    cycles(200000);
    if (!finished) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    cycles(3);
    rst_n = 1'b1;
    cycles(1);
    // R1 reset state
    check("R1 req0", {31'b0, req0}, 0);
    check("R1 req1", {31'b0, req1}, 0);
    check("R1 wake", {31'b0, wake}, 0);
    rd_exp(8'h40, 32'h0, "R1 trig0");
    rd_exp(8'h50, 32'h0, "R1 trig2");
    rd_exp(8'h58, 32'hFFFF_FFFF, "R1 source");
    rd_exp(8'h70, 32'h0, "R1 mask");
    rd_exp(8'h78, 32'h0, "R1 rise");
    rd_exp(8'h80, 32'h0, "R1 test");

    // R2 set/clear planes
    wr(8'h70, 32'h0000_FF0F);
    wr(8'h74, 32'h0000_000F);
    rd_exp(8'h70, 32'h0000_FF00, "R2 mask set/clear");
    wr(8'h74, 32'hFFFF_FFFF);
    wr(8'h68, 32'h8000_0001);
    wr(8'h6C, 32'h0000_0001);
    rd_exp(8'h68, 32'h8000_0000, "R2 wake plane");
    wr(8'h6C, 32'hFFFF_FFFF);
    // R5 writes at the pending addresses clear planes
    wr(8'h5C, 32'h0000_00FF);
    rd_exp(8'h58, 32'hFFFF_FF00, "R5 source clear via 0x5C");
    wr(8'h50, 32'h0000_0003);
    wr(8'h54, 32'h0000_0001);
    rd_exp(8'h50, 32'h0000_0002, "R5 trig2 clear via 0x54");
    wr(8'h54, 32'hFFFF_FFFF);

    // R3 codes: b0 rise, b1 fall, b2 both, b3 high, b4 low, b5 off
    wr(8'h40, 32'h0000_000D);
    wr(8'h48, 32'h0000_0016);
    wr(8'h50, 32'h0000_0018);
    wr(8'h60, 32'h0000_0018); // b3,b4 to req0
    cycles(1);
    check("R7 masked low-level source", {31'b0, req0}, 0);
    rd_exp(8'h54, 32'h0, "R7 pending0 masked");
    wr(8'h70, 32'h0000_003F);
    check("R7 unmasked low-level source", {31'b0, req0}, 1);
    rd_exp(8'h54, 32'h0000_0010, "R3 low level active at 0");

    // R9 latency: only b0 and b3 unmasked
    wr(8'h74, 32'h0000_0036);
    check("R9 idle req0", {31'b0, req0}, 0);
    src_in = 32'h0000_0009;
    cycles(1);
    check("R9 level after 1 edge", {31'b0, req0}, 0);
    cycles(1);
    check("R9 level after 2 edges", {31'b0, req0}, 1);
    check("R9 capture after 2 edges", {31'b0, req1}, 0);
    cycles(1);
    check("R9 capture after 3 edges", {31'b0, req1}, 1);
    rd_exp(8'h78, 32'h0000_0001, "R4 rise capture b0");

    src_in = 32'h0000_003F;
    cycles(4);
    rd_exp(8'h78, 32'h0000_0005, "R3 rise only for rise/both, not off");
    rd_exp(8'h7C, 32'h0, "R3 no fall capture on rising");
    src_in = 32'h0;
    cycles(4);
    rd_exp(8'h7C, 32'h0000_0006, "R3 fall capture fall/both");
    rd_exp(8'h78, 32'h0000_0005, "R4 sticky after idle");

    wr(8'h70, 32'h0000_0036);
    rd_exp(8'h5C, 32'h0000_0007, "R6 pending1 steer 0");
    rd_exp(8'h54, 32'h0000_0010, "R6 pending0 steer 1");
    check("R8 wake none enabled", {31'b0, wake}, 0);
    wr(8'h68, 32'h0000_0002);
    check("R8 wake from b1", {31'b0, wake}, 1);
    wr(8'h78, 32'h0000_0001);
    wr(8'h7C, 32'h0000_0006);
    check("R8 wake drops", {31'b0, wake}, 0);
    rd_exp(8'h78, 32'h0000_0004, "R4 rise clear");
    rd_exp(8'h5C, 32'h0000_0004, "R4 pending1 after clears");

    // R4 clear in the same cycle as a new edge
    src_in = 32'h0000_0001;
    cycles(2);
    wr(8'h78, 32'h0000_0001);
    rd_exp(8'h78, 32'h0000_0005, "R4 edge wins over clear");

    // R6 steering move
    wr(8'h60, 32'h0000_0004);
    rd_exp(8'h54, 32'h0000_0014, "R6 b2 moved to req0");
    rd_exp(8'h5C, 32'h0000_0001, "R6 req1 keeps b0");
    check("R6 req1 high", {31'b0, req1}, 1);

    // R10 test word and unmapped read
    wr(8'h80, 32'hA5A5_5A5A);
    rd_exp(8'h80, 32'hA5A5_5A5A, "R10 test word");
    rd_exp(8'h44, 32'h0, "R10 unmapped read");

    cycles(2);
    check("R11 all reads answered", sb.size(), 0);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule